// File: doc/BRIEF.md
# Typed Control/Status Register Bank

This block sits between an AXI4-Lite slave port and the configuration and status pins of an accelerator. Software reaches four 32-bit word registers at fixed byte offsets from the bank base, four bytes apart. Each register has one of three behaviours. A storage register keeps what was last written. A pulse register turns a write into a one-clock strobe on its field pins. A status register returns the live value of accelerator inputs, and writes to it have no effect.

Each register packs several named fields, and each field drives or samples a discrete accelerator pin. Field widths come from parameters, and field offsets are derived from them. The address map is fixed at elaboration. Any other offset in the decoded window answers with an error response.

Top module: `csr_bank`

## Requirements
- R1: After reset every field output is zero, BVALID and RVALID are low, and AWREADY, WREADY and ARREADY are high.
- R2: A write address and its write data may be accepted in the same cycle or in either order. Each write then produces exactly one response, and BVALID and BRESP stay unchanged until BREADY is seen.
- R3: Offset 0x0 is a storage register holding three fields: algorithm select in bits 9:8 (cfg_algo), pattern in bits 5:4 (cfg_pattern) and a format flag in bit 0 (cfg_flag). The fields keep their value until a later write to this offset changes them.
- R4: Offset 0x4 is a storage register holding the frame width in bits DIM_W-1:0 (dim_width) and the frame height in bits 2*DIM_W-1:DIM_W (dim_height). With the default DIM_W of 13 these are bits 12:0 and 25:13.
- R5: A write to a storage register changes only the bytes whose WSTRB bit is set. Bit n of WSTRB selects bits 8n+7:8n.
- R6: Offset 0x8 is a pulse register with cmd_go in bit 0 and cmd_abort in bit 1. The strobe-qualified written value appears on these pins for exactly one clock, in the cycle after the write response handshake. The pins are zero at all other times, and a later read of the offset returns zero.
- R7: Offset 0xC is a status register that reads st_busy in bit 0 and st_count in bits CNT_W+7:8. Writes to it return OKAY and change no output.
- R8: Status inputs are captured in the cycle of the read address handshake. RDATA and RRESP stay unchanged while RVALID is high and RREADY is low.
- R9: A read returns zero in every bit that belongs to no field.
- R10: A word-aligned address at 0x10 or above inside the decoded window returns SLVERR (2'b10), and so does an address whose two low bits are not zero. For such a read RDATA is zero, and such a write changes no register. Mapped accesses return OKAY (2'b00).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| s_awaddr | input | ADDR_W | Write byte address |
| s_awvalid | input | 1 | Write address valid |
| s_awready | output | 1 | Write address ready |
| s_wdata | input | 32 | Write data |
| s_wstrb | input | 4 | Write byte strobes |
| s_wvalid | input | 1 | Write data valid |
| s_wready | output | 1 | Write data ready |
| s_bresp | output | 2 | Write response |
| s_bvalid | output | 1 | Write response valid |
| s_bready | input | 1 | Write response ready |
| s_araddr | input | ADDR_W | Read byte address |
| s_arvalid | input | 1 | Read address valid |
| s_arready | output | 1 | Read address ready |
| s_rdata | output | 32 | Read data |
| s_rresp | output | 2 | Read response |
| s_rvalid | output | 1 | Read data valid |
| s_rready | input | 1 | Read data ready |
| cfg_algo | output | 2 | Algorithm select field |
| cfg_pattern | output | 2 | Input pattern field |
| cfg_flag | output | 1 | Output format flag |
| dim_width | output | DIM_W | Frame width field |
| dim_height | output | DIM_W | Frame height field |
| cmd_go | output | 1 | One-clock start strobe |
| cmd_abort | output | 1 | One-clock abort strobe |
| st_busy | input | 1 | Accelerator busy status |
| st_count | input | CNT_W | Accelerator progress count |

## Verification
A corrupted storage word appears directly on its field pins, and on the next read of that offset, so it is seen within a cycle of the faulty write. A pulse register that holds its value lasts longer than one clock, and one that fires early appears in the wrong cycle. Either fault is visible in the two cycles that follow the write response. The bench compares every field pin against a model of the register map after each write, including bytes masked by strobes and writes to unmapped or misaligned offsets. A wrong capture point for status shows up as RDATA changing while the response is stalled, because the status inputs are altered during that stall.

// File: rtl/csrb_pkg.sv
package csrb_pkg;

    localparam int DATA_W = 32;
    localparam int STRB_W = DATA_W / 8;
    localparam int IDX_W  = 6;

    // register word indices (offset = index * 4)
    localparam int IDX_CTRL = 0;
    localparam int IDX_SIZE = 1;
    localparam int IDX_KICK = 2;
    localparam int IDX_STAT = 3;

    // field positions that are fixed by the map
    localparam int ALGO_LSB  = 8;
    localparam int ALGO_W    = 2;
    localparam int PAT_LSB   = 4;
    localparam int PAT_W     = 2;
    localparam int FLAG_BIT  = 0;
    localparam int GO_BIT    = 0;
    localparam int ABORT_BIT = 1;
    localparam int BUSY_BIT  = 0;
    localparam int CNT_LSB   = 8;

    localparam logic [1:0] RESP_OKAY   = 2'b00;
    localparam logic [1:0] RESP_SLVERR = 2'b10;

    typedef enum logic [1:0] {
        KIND_STORE,
        KIND_PULSE,
        KIND_STATUS,
        KIND_NONE
    } reg_kind_e;

    typedef struct packed {
        logic [IDX_W-1:0]  idx;
        logic [DATA_W-1:0] data;
        logic [STRB_W-1:0] strb;
    } wr_req_t;

    function automatic reg_kind_e kind_of(input logic [IDX_W-1:0] idx);
        case (idx)
            IDX_W'(IDX_CTRL), IDX_W'(IDX_SIZE): return KIND_STORE;
            IDX_W'(IDX_KICK):                   return KIND_PULSE;
            IDX_W'(IDX_STAT):                   return KIND_STATUS;
            default:                            return KIND_NONE;
        endcase
    endfunction

    function automatic logic [DATA_W-1:0] strb_mask(input logic [STRB_W-1:0] strb);
        logic [DATA_W-1:0] m;
        for (int b = 0; b < STRB_W; b++) begin
            m[b*8 +: 8] = {8{strb[b]}};
        end
        return m;
    endfunction

endpackage

// File: rtl/csrb_wr_chan.sv
module csrb_wr_chan
    import csrb_pkg::*;
#(
    parameter int ADDR_W = 5
) (
    input  logic                clk,
    input  logic                rst,
    input  logic [ADDR_W-1:0]   awaddr,
    input  logic                awvalid,
    output logic                awready,
    input  logic [DATA_W-1:0]   wdata,
    input  logic [STRB_W-1:0]   wstrb,
    input  logic                wvalid,
    output logic                wready,
    output logic [1:0]          bresp,
    output logic                bvalid,
    input  logic                bready,
    output logic                commit_hit,
    output wr_req_t             commit_req,
    output logic                b_fire
);
    logic              aw_have, w_have, commit, addr_ok;
    logic [ADDR_W-1:0] aw_q;
    logic [DATA_W-1:0] data_q;
    logic [STRB_W-1:0] strb_q;

    assign awready = !aw_have;
    assign wready  = !w_have;
    assign commit  = aw_have && w_have && !bvalid;
    assign b_fire  = bvalid && bready;

    assign commit_req.idx  = IDX_W'(aw_q[ADDR_W-1:2]);
    assign commit_req.data = data_q;
    assign commit_req.strb = strb_q;
    assign addr_ok    = (aw_q[1:0] == 2'b00) && (kind_of(commit_req.idx) != KIND_NONE);
    assign commit_hit = commit && addr_ok;

    always_ff @(posedge clk) begin
        if (rst) begin
            aw_have <= 1'b0;
            w_have  <= 1'b0;
            aw_q    <= '0;
            data_q  <= '0;
            strb_q  <= '0;
            bvalid  <= 1'b0;
            bresp   <= RESP_OKAY;
        end else begin
            if (awvalid && awready) begin
                aw_have <= 1'b1;
                aw_q    <= awaddr;
            end else if (commit) begin
                aw_have <= 1'b0;
            end
            if (wvalid && wready) begin
                w_have <= 1'b1;
                data_q <= wdata;
                strb_q <= wstrb;
            end else if (commit) begin
                w_have <= 1'b0;
            end
            if (commit) begin
                bvalid <= 1'b1;
                bresp  <= addr_ok ? RESP_OKAY : RESP_SLVERR;
            end else if (b_fire) begin
                bvalid <= 1'b0;
            end
        end
    end

    AST_B_HOLD: assert property (@(posedge clk) disable iff (rst)
        bvalid && !bready |=> bvalid && $stable(bresp)); // R2
    AST_ONE_RESP: assert property (@(posedge clk) disable iff (rst)
        b_fire |=> !bvalid); // R2

endmodule

// File: rtl/csrb_rd_chan.sv
module csrb_rd_chan
    import csrb_pkg::*;
#(
    parameter int ADDR_W = 5
) (
    input  logic                clk,
    input  logic                rst,
    input  logic [ADDR_W-1:0]   araddr,
    input  logic                arvalid,
    output logic                arready,
    output logic [DATA_W-1:0]   rdata,
    output logic [1:0]          rresp,
    output logic                rvalid,
    input  logic                rready,
    output logic [IDX_W-1:0]    rd_idx,
    input  logic [DATA_W-1:0]   rd_word
);
    logic hit;

    assign arready = !rvalid;
    assign rd_idx  = IDX_W'(araddr[ADDR_W-1:2]);
    assign hit     = (araddr[1:0] == 2'b00) && (kind_of(rd_idx) != KIND_NONE);

    always_ff @(posedge clk) begin
        if (rst) begin
            rvalid <= 1'b0;
            rdata  <= '0;
            rresp  <= RESP_OKAY;
        end else if (arvalid && arready) begin
            rvalid <= 1'b1;
            rdata  <= hit ? rd_word : '0;
            rresp  <= hit ? RESP_OKAY : RESP_SLVERR;
        end else if (rvalid && rready) begin
            rvalid <= 1'b0;
        end
    end

    AST_R_HOLD: assert property (@(posedge clk) disable iff (rst)
        rvalid && !rready |=> rvalid && $stable(rdata) && $stable(rresp)); // R8

endmodule

// File: rtl/csrb_regs.sv
module csrb_regs
    import csrb_pkg::*;
#(
    parameter int DIM_W = 13,
    parameter int CNT_W = 16
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               commit_hit,
    input  wr_req_t            commit_req,
    input  logic               b_fire,
    input  logic [IDX_W-1:0]   rd_idx,
    output logic [DATA_W-1:0]  rd_word,
    input  logic               st_busy,
    input  logic [CNT_W-1:0]   st_count,
    output logic [ALGO_W-1:0]  cfg_algo,
    output logic [PAT_W-1:0]   cfg_pattern,
    output logic               cfg_flag,
    output logic [DIM_W-1:0]   dim_width,
    output logic [DIM_W-1:0]   dim_height,
    output logic               cmd_go,
    output logic               cmd_abort
);
    localparam int NUM_STORE  = 2;
    localparam int HEIGHT_LSB = DIM_W;
    localparam logic [DATA_W-1:0] CTRL_MASK =
        (DATA_W'((1 << ALGO_W) - 1) << ALGO_LSB) |
        (DATA_W'((1 << PAT_W) - 1) << PAT_LSB) |
        (DATA_W'(1) << FLAG_BIT);
    localparam logic [DATA_W-1:0] SIZE_MASK = DATA_W'((64'd1 << (2 * DIM_W)) - 64'd1);
    localparam logic [DATA_W-1:0] KICK_MASK = (DATA_W'(1) << GO_BIT) | (DATA_W'(1) << ABORT_BIT);

    logic [DATA_W-1:0] store_q [NUM_STORE];
    logic [DATA_W-1:0] wmask, kick_hold, kick_out, stat_word;

    assign wmask = strb_mask(commit_req.strb);

    for (genvar i = 0; i < NUM_STORE; i++) begin : g_store
        localparam logic [DATA_W-1:0] MASK = (i == IDX_CTRL) ? CTRL_MASK : SIZE_MASK;
        always_ff @(posedge clk) begin
            if (rst) begin
                store_q[i] <= '0;
            end else if (commit_hit && commit_req.idx == IDX_W'(i)) begin
                store_q[i] <= (store_q[i] & ~wmask) | (commit_req.data & wmask & MASK);
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            kick_hold <= '0;
            kick_out  <= '0;
        end else begin
            if (commit_hit && commit_req.idx == IDX_W'(IDX_KICK)) begin
                kick_hold <= commit_req.data & wmask & KICK_MASK;
            end else if (b_fire) begin
                kick_hold <= '0;
            end
            kick_out <= b_fire ? kick_hold : '0;
        end
    end

    assign stat_word = (DATA_W'(st_count) << CNT_LSB) | (DATA_W'(st_busy) << BUSY_BIT);

    always_comb begin
        case (rd_idx)
            IDX_W'(IDX_CTRL): rd_word = store_q[IDX_CTRL];
            IDX_W'(IDX_SIZE): rd_word = store_q[IDX_SIZE];
            IDX_W'(IDX_KICK): rd_word = kick_hold | kick_out;
            IDX_W'(IDX_STAT): rd_word = stat_word;
            default:          rd_word = '0;
        endcase
    end

    assign cfg_algo    = store_q[IDX_CTRL][ALGO_LSB +: ALGO_W];
    assign cfg_pattern = store_q[IDX_CTRL][PAT_LSB +: PAT_W];
    assign cfg_flag    = store_q[IDX_CTRL][FLAG_BIT];
    assign dim_width   = store_q[IDX_SIZE][0 +: DIM_W];
    assign dim_height  = store_q[IDX_SIZE][HEIGHT_LSB +: DIM_W];
    assign cmd_go      = kick_out[GO_BIT];
    assign cmd_abort   = kick_out[ABORT_BIT];

    AST_PULSE_SINGLE: assert property (@(posedge clk) disable iff (rst)
        (cmd_go || cmd_abort) |=> !cmd_go && !cmd_abort); // R6
    AST_PULSE_AFTER_B: assert property (@(posedge clk) disable iff (rst)
        (cmd_go || cmd_abort) |-> $past(b_fire)); // R6
    AST_CTRL_HOLD: assert property (@(posedge clk) disable iff (rst)
        !commit_hit |=> $stable({cfg_algo, cfg_pattern, cfg_flag})); // R3
    AST_SIZE_HOLD: assert property (@(posedge clk) disable iff (rst)
        !commit_hit |=> $stable({dim_width, dim_height})); // R4

endmodule

// File: rtl/csr_bank.sv
module csr_bank
    import csrb_pkg::*;
#(
    parameter int ADDR_W = 5,
    parameter int DIM_W  = 13,
    parameter int CNT_W  = 16
) (
    input  logic                clk,
    input  logic                rst,
    input  logic [ADDR_W-1:0]   s_awaddr,
    input  logic                s_awvalid,
    output logic                s_awready,
    input  logic [31:0]         s_wdata,
    input  logic [3:0]          s_wstrb,
    input  logic                s_wvalid,
    output logic                s_wready,
    output logic [1:0]          s_bresp,
    output logic                s_bvalid,
    input  logic                s_bready,
    input  logic [ADDR_W-1:0]   s_araddr,
    input  logic                s_arvalid,
    output logic                s_arready,
    output logic [31:0]         s_rdata,
    output logic [1:0]          s_rresp,
    output logic                s_rvalid,
    input  logic                s_rready,
    output logic [1:0]          cfg_algo,
    output logic [1:0]          cfg_pattern,
    output logic                cfg_flag,
    output logic [DIM_W-1:0]    dim_width,
    output logic [DIM_W-1:0]    dim_height,
    output logic                cmd_go,
    output logic                cmd_abort,
    input  logic                st_busy,
    input  logic [CNT_W-1:0]    st_count
);
    logic              commit_hit, b_fire;
    wr_req_t           commit_req;
    logic [IDX_W-1:0]  rd_idx;
    logic [DATA_W-1:0] rd_word;

    initial begin
        if (ADDR_W - 2 > IDX_W || 2 * DIM_W > DATA_W || CNT_W + CNT_LSB > DATA_W)
            $error("csr_bank: parameter out of range");
    end

    csrb_wr_chan #(.ADDR_W(ADDR_W)) u_wr (
        .clk(clk), .rst(rst),
        .awaddr(s_awaddr), .awvalid(s_awvalid), .awready(s_awready),
        .wdata(s_wdata), .wstrb(s_wstrb), .wvalid(s_wvalid), .wready(s_wready),
        .bresp(s_bresp), .bvalid(s_bvalid), .bready(s_bready),
        .commit_hit(commit_hit), .commit_req(commit_req), .b_fire(b_fire)
    );

    csrb_rd_chan #(.ADDR_W(ADDR_W)) u_rd (
        .clk(clk), .rst(rst),
        .araddr(s_araddr), .arvalid(s_arvalid), .arready(s_arready),
        .rdata(s_rdata), .rresp(s_rresp), .rvalid(s_rvalid), .rready(s_rready),
        .rd_idx(rd_idx), .rd_word(rd_word)
    );

    csrb_regs #(.DIM_W(DIM_W), .CNT_W(CNT_W)) u_regs (
        .clk(clk), .rst(rst),
        .commit_hit(commit_hit), .commit_req(commit_req), .b_fire(b_fire),
        .rd_idx(rd_idx), .rd_word(rd_word),
        .st_busy(st_busy), .st_count(st_count),
        .cfg_algo(cfg_algo), .cfg_pattern(cfg_pattern), .cfg_flag(cfg_flag),
        .dim_width(dim_width), .dim_height(dim_height),
        .cmd_go(cmd_go), .cmd_abort(cmd_abort)
    );

    AST_RESP_CODE: assert property (@(posedge clk) disable iff (rst)
        s_bvalid |-> (s_bresp == RESP_OKAY || s_bresp == RESP_SLVERR)); // R10

endmodule

// File: tb/csr_bank_bench.sv
`timescale 1ns/1ps
module csr_bank_bench;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [4:0]  s_awaddr = '0, s_araddr = '0;
    logic        s_awvalid = 1'b0, s_wvalid = 1'b0, s_bready = 1'b0;
    logic        s_arvalid = 1'b0, s_rready = 1'b0;
    logic [31:0] s_wdata = '0;
    logic [3:0]  s_wstrb = '0;
    logic        s_awready, s_wready, s_bvalid, s_arready, s_rvalid;
    logic [1:0]  s_bresp, s_rresp;
    logic [31:0] s_rdata;
    logic [1:0]  cfg_algo, cfg_pattern;
    logic        cfg_flag, cmd_go, cmd_abort;
    logic [12:0] dim_width, dim_height;
    logic        st_busy = 1'b0;
    logic [15:0] st_count = '0;

    int checks = 0;
    int errors = 0;
    logic [31:0] exp_ctrl = '0, exp_size = '0;

    always #10 clk = ~clk;

    csr_bank u_csr_bank (.*);

    task automatic chk(input string req, input logic [31:0] got, input logic [31:0] exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s: got %h expected %h", req, got, exp);
        end
    endtask

    function automatic logic [31:0] smask(input logic [3:0] s);
        return {{8{s[3]}}, {8{s[2]}}, {8{s[1]}}, {8{s[0]}}};
    endfunction

    function automatic bit mapped(input logic [4:0] a);
        return a[1:0] == 2'b00 && a[4:2] < 3'd4;
    endfunction

    function automatic logic [31:0] exp_read(input logic [4:0] a, input logic b, input logic [15:0] c);
        if (!mapped(a)) return '0;
        case (a[4:2])
            3'd0: return exp_ctrl;
            3'd1: return exp_size;
            3'd3: return {8'h00, c, 7'h00, b};
            default: return '0;
        endcase
    endfunction

    task automatic check_outs(input string req);
        chk(req, {22'd0, cfg_algo, 2'd0, cfg_pattern, 3'd0, cfg_flag},  exp_ctrl);
        chk(req, {6'd0, dim_height, dim_width}, exp_size);
    endtask

    task automatic axi_wr(input logic [4:0] a, input logic [31:0] d, input logic [3:0] s,
                          input int order, input int bdelay);
        bit awd = 0, wd = 0;
        int cyc = 0;
        logic [1:0] resp;
        logic [1:0] p1, p2, exp_p;
        @(negedge clk);
        while (!(awd && wd)) begin
            s_awaddr  = a;
            s_awvalid = !awd && (order != 2 || cyc >= 2);
            s_wdata   = d;
            s_wstrb   = s;
            s_wvalid  = !wd && (order != 1 || cyc >= 2);
            #1;
            begin
                logic af, wf;
                af = s_awvalid && s_awready;
                wf = s_wvalid && s_wready;
                @(posedge clk);
                if (af) awd = 1;
                if (wf) wd = 1;
            end
            @(negedge clk);
            cyc++;
        end
        s_awvalid = 0;
        s_wvalid  = 0;
        while (!s_bvalid) @(negedge clk);
        resp = s_bresp;
        for (int i = 0; i < bdelay; i++) begin
            @(negedge clk);
            chk("R2 bvalid hold", {31'd0, s_bvalid}, 32'd1);
            chk("R2 bresp hold", {30'd0, s_bresp}, {30'd0, resp});
        end
        chk(mapped(a) ? "R2 bresp okay" : "R10 bresp slverr", {30'd0, resp},
            mapped(a) ? 32'd0 : 32'd2);
        s_bready = 1;
        @(posedge clk);
        @(negedge clk);
        s_bready = 0;
        chk("R2 single response", {31'd0, s_bvalid}, 32'd0);
        p1 = {cmd_abort, cmd_go};
        @(negedge clk);
        p2 = {cmd_abort, cmd_go};
        exp_p = (a == 5'h08) ? (d[1:0] & {s[0], s[0]}) : 2'b00;
        chk("R6 pulse after response", {30'd0, p1}, {30'd0, exp_p});
        chk("R6 pulse one cycle", {30'd0, p2}, 32'd0);
        if (a == 5'h00) exp_ctrl = (exp_ctrl & ~smask(s)) | (d & smask(s) & 32'h0000_0331);
        if (a == 5'h04) exp_size = (exp_size & ~smask(s)) | (d & smask(s) & 32'h03FF_FFFF);
        check_outs(a == 5'h04 ? "R4 size fields" : (s != 4'hF ? "R5 strobes" : "R3 ctrl fields"));
    endtask

    task automatic axi_rd(input logic [4:0] a, input int hold);
        logic [31:0] exp_d, got;
        logic [1:0] got_r;
        @(negedge clk);
        st_busy  = 1'($urandom);
        st_count = 16'($urandom);
        exp_d    = exp_read(a, st_busy, st_count);
        s_araddr  = a;
        s_arvalid = 1;
        #1;
        chk("R8 arready", {31'd0, s_arready}, 32'd1);
        @(posedge clk);
        @(negedge clk);
        s_arvalid = 0;
        st_busy  = ~st_busy;
        st_count = ~st_count;
        got = s_rdata;
        got_r = s_rresp;
        for (int i = 0; i < hold; i++) begin
            @(negedge clk);
            chk("R8 rdata stable", s_rdata, got);
            chk("R8 rvalid held", {31'd0, s_rvalid}, 32'd1);
        end
        chk(a == 5'h0C ? "R7 status read" : (mapped(a) ? "R9 read value" : "R10 read zero"),
            got, exp_d);
        chk(mapped(a) ? "R9 rresp okay" : "R10 rresp slverr", {30'd0, got_r},
            mapped(a) ? 32'd0 : 32'd2);
        s_rready = 1;
        @(posedge clk);
        @(negedge clk);
        s_rready = 0;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        void'($urandom(32'd1234));
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 0;
        // R1 reset state
        chk("R1 bvalid", {31'd0, s_bvalid}, 32'd0);
        chk("R1 rvalid", {31'd0, s_rvalid}, 32'd0);
        chk("R1 readies", {29'd0, s_awready, s_wready, s_arready}, 32'd7);
        chk("R1 pulses", {30'd0, cmd_abort, cmd_go}, 32'd0);
        check_outs("R1 fields");

        // directed cases
        axi_wr(5'h00, 32'hFFFF_FFFF, 4'hF, 0, 0);      // R3, R9 unused bits dropped
        axi_rd(5'h00, 2);                               // R9
        axi_wr(5'h04, {6'd0, 13'd480, 13'd640}, 4'hF, 1, 2); // R4 aw first
        axi_wr(5'h04, 32'hFFFF_FFFF, 4'h2, 2, 1);       // R5 w first, one byte
        axi_rd(5'h04, 1);
        axi_wr(5'h08, 32'h0000_0001, 4'hF, 0, 0);       // R6 go
        axi_wr(5'h08, 32'h0000_0003, 4'hF, 1, 3);       // R6 both
        axi_wr(5'h08, 32'h0000_0003, 4'h0, 0, 0);       // R5 masked pulse
        axi_rd(5'h08, 0);                               // R6 reads zero
        axi_wr(5'h0C, 32'hFFFF_FFFF, 4'hF, 0, 0);       // R7 ignored
        axi_rd(5'h0C, 3);                               // R7, R8
        axi_wr(5'h10, 32'hFFFF_FFFF, 4'hF, 0, 0);       // R10 unmapped
        axi_wr(5'h01, 32'h0000_0000, 4'hF, 2, 0);       // R10 misaligned
        axi_rd(5'h1C, 1);                               // R10
        axi_rd(5'h02, 0);                               // R10

        // constrained random mix
        for (int n = 0; n < 300; n++) begin
            logic [4:0] a;
            a = ($urandom % 8 == 0) ? 5'($urandom) : {3'($urandom % 6), 2'b00};
            if ($urandom % 2 == 0)
                axi_wr(a, $urandom, 4'($urandom), int'($urandom % 3), int'($urandom % 3));
            else
                axi_rd(a, int'($urandom % 3));
        end

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule